// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Read Streaming

This block is the slave end of a two-wire serial memory. It watches the clock line (SCL) and the data line (SDA) with the system clock. It recognises start, repeated-start and stop conditions and answers to a 7-bit device address. That address is a fixed `1010` prefix followed by three strap pins, so up to eight such slaves can share one bus. The block pulls SDA low through an open-drain style enable and never drives it high.

A master reads in one of three ways:

- **Random read:** a write header with a two-byte word address, then a repeated start and a read header.
- **Current-address read:** a read header with no word address, which continues from the internal counter.
- **Streaming read:** after either of the above, each master acknowledge fetches the next byte. The address counter rolls over at the top of the array.

A write header followed by one data byte stores that byte. A side port loads the array directly, which is used to preload contents for test. The array holds `2**ADDR_W` bytes. `ADDR_W = 14` gives the full 16 KiB device; the default build uses a 2 KiB array so that elaboration stays small.

The controller is one state machine:

- **States:**
  - IDLE: waits for a start.
  - DEV: shifts in the device byte.
  - DEV_ACK, AHI_ACK, ALO_ACK, WDAT_ACK: the acknowledge slots.
  - AHI, ALO: the word address bytes.
  - WDAT: the write data byte.
  - RDAT: shifts a byte out.
  - MACK: the master's acknowledge slot.
  - SKIP: ignores the bus until the next start or stop.
- **Transitions:**
  - Any state goes to DEV on a start and to IDLE on a stop.
  - DEV goes to DEV_ACK on an address hit, or to SKIP on a miss.
  - DEV_ACK goes to RDAT when the R/W bit is 1, otherwise to AHI.
  - AHI goes to AHI_ACK, then ALO.
  - ALO goes to ALO_ACK, then WDAT.
  - WDAT goes to WDAT_ACK, then SKIP.
  - RDAT goes to MACK.
  - MACK goes back to RDAT on an acknowledge, or to IDLE on a not-acknowledge.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset SDA is released (`sda_oe_o` = 0) and the internal address counter is 0, so a first current-address read returns the byte at address 0.
- R2: The slave acknowledges (pulls SDA low in the ninth clock) only a device byte whose upper seven bits equal `1010` followed by `strap_i[2:0]`; bit 0 of that byte is R/W, with 1 meaning read. On any other device byte it leaves SDA released until the next start or stop.
- R3: In a write header, the high word address byte comes first and the low byte second. Both are acknowledged, and word address bits at or above `ADDR_W` are ignored. A repeated start with a read header then returns the byte at that address.
- R4: Read data leaves most significant bit first. The slave's SDA enable changes only while SCL is low, except when a start or stop releases it.
- R5: When the master acknowledges a read byte, the next byte sent comes from the following address (N, N+1, ...), for as many bytes as the master acknowledges.
- R6: The address counter rolls over from `2**ADDR_W-1` to 0 during a streaming read and keeps sending data.
- R7: A master not-acknowledge after a read byte ends the read. SDA stays released, and further clocks before the next start produce no SDA drive.
- R8: A start or stop in the middle of any byte abandons that transfer and restarts bit counting. A following read header is then handled normally, and the counter is left unchanged.
- R9: After every byte read or written, the counter holds that byte's address plus one, and a current-address read continues from it.
- R10: In a write header, the first data byte after the two address bytes is stored at the word address and acknowledged. Any further data byte in the same transfer is not acknowledged and is not stored.
- R11: When `pl_we_i` is high, `pl_data_i` is written to `pl_addr_i` at the clock edge. This load takes priority over a bus write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (includes own drive) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Low three device address bits |
| pl_we_i | input | 1 | Direct array write strobe |
| pl_addr_i | input | ADDR_W | Direct array write address |
| pl_data_i | input | 8 | Direct array write data |

## Verification
A wrong internal state shows at the ports within a byte of the fault. A bad bit count or phase shifts the acknowledge slot off the ninth clock, and the master sees a missing acknowledge or a corrupted data byte at once. A counter that is wrong, fails to wrap or moves on a refused byte shows up on the next streamed or current-address byte. An address decoder that is too loose or too strict shows on the ninth clock of the header. Mid-byte start and stop aborts are followed directly by a read, so a stuck state shows as a missing acknowledge on that very header.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_MACK,
        ST_SKIP
    } sl_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic scl_s, scl_p, sda_p;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[SYNC_STAGES-1];
    assign sda_s = sda_ff[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] value
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= load_val;
        else if (inc)  value <= value + 1'b1;
    end

endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    input  logic              pl_we_i,
    input  logic [ADDR_W-1:0] pl_addr_i,
    input  logic [7:0]        pl_data_i
);

    localparam int HI_W = ADDR_W - 8;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic bus_cond;

    sl_state_t st_q, st_d;
    logic [2:0]      bit_q;
    logic [7:0]      sh_q;
    logic [HI_W-1:0] hi_q;
    logic            ack_ph_q;
    logic            rw_q;
    logic            mack_q;
    logic            oe_q;

    logic [7:0]        byte_in;
    logic              last_bit;
    logic              dev_hit;
    logic              ctr_load, ctr_inc, bus_wr, rd_fetch;
    logic [ADDR_W-1:0] ctr_val;
    logic [7:0]        mem_rd;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign bus_cond = start_det | stop_det;
    assign byte_in  = {sh_q[6:0], sda_s};
    assign last_bit = (bit_q == 3'd7);
    assign dev_hit  = (byte_in[7:1] == {DEV_PREFIX, strap_i});

    // strobes to the counter and the array
    always_comb begin
        ctr_load = !bus_cond && (st_q == ST_ALO) && scl_rise && last_bit;
        bus_wr   = !bus_cond && (st_q == ST_WDAT) && scl_rise && last_bit;
        rd_fetch = !bus_cond && scl_fall &&
                   (((st_q == ST_DEV_ACK) && ack_ph_q && rw_q) ||
                    ((st_q == ST_MACK) && mack_q));
        ctr_inc  = bus_wr | rd_fetch;
    end

    i2c_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val ({hi_q, byte_in}),
        .inc      (ctr_inc),
        .value    (ctr_val)
    );

    assign mem_we    = pl_we_i | bus_wr;
    assign mem_waddr = pl_we_i ? pl_addr_i : ctr_val;
    assign mem_wdata = pl_we_i ? pl_data_i : byte_in;

    i2c_mem_store #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (ctr_val),
        .rdata (mem_rd)
    );

    // next state
    always_comb begin
        st_d = st_q;
        if (start_det) begin
            st_d = ST_DEV;
        end else if (stop_det) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_SKIP: st_d = st_q;
                ST_DEV:      if (scl_rise && last_bit) st_d = dev_hit ? ST_DEV_ACK : ST_SKIP;
                ST_AHI:      if (scl_rise && last_bit) st_d = ST_AHI_ACK;
                ST_ALO:      if (scl_rise && last_bit) st_d = ST_ALO_ACK;
                ST_WDAT:     if (scl_rise && last_bit) st_d = ST_WDAT_ACK;
                ST_DEV_ACK:  if (scl_fall && ack_ph_q) st_d = rw_q ? ST_RDAT : ST_AHI;
                ST_AHI_ACK:  if (scl_fall && ack_ph_q) st_d = ST_ALO;
                ST_ALO_ACK:  if (scl_fall && ack_ph_q) st_d = ST_WDAT;
                ST_WDAT_ACK: if (scl_fall && ack_ph_q) st_d = ST_SKIP;
                ST_RDAT:     if (scl_fall && last_bit) st_d = ST_MACK;
                ST_MACK:     if (scl_fall) st_d = mack_q ? ST_RDAT : ST_IDLE;
                default:     st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // shifter, bit counter and SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q    <= '0;
            sh_q     <= '0;
            hi_q     <= '0;
            ack_ph_q <= 1'b0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            oe_q     <= 1'b0;
        end else if (bus_cond) begin
            bit_q    <= '0;
            ack_ph_q <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            unique case (st_q)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise) begin
                        sh_q  <= byte_in;
                        bit_q <= bit_q + 3'd1;
                        if (last_bit) begin
                            ack_ph_q <= 1'b0;
                            if (st_q == ST_DEV) rw_q <= sda_s;
                            if (st_q == ST_AHI) hi_q <= byte_in[HI_W-1:0];
                        end
                    end
                end
                ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        if (!ack_ph_q) begin
                            oe_q     <= 1'b1;
                            ack_ph_q <= 1'b1;
                        end else begin
                            ack_ph_q <= 1'b0;
                            if (rd_fetch) begin
                                sh_q  <= mem_rd;
                                oe_q  <= ~mem_rd[7];
                                bit_q <= '0;
                            end else begin
                                oe_q <= 1'b0;
                            end
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (last_bit) begin
                            oe_q  <= 1'b0;
                            bit_q <= '0;
                        end else begin
                            oe_q  <= ~sh_q[6];
                            sh_q  <= {sh_q[6:0], 1'b0};
                            bit_q <= bit_q + 3'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (rd_fetch) begin
                        sh_q  <= mem_rd;
                        oe_q  <= ~mem_rd[7];
                        bit_q <= '0;
                    end
                end
                ST_IDLE, ST_SKIP: oe_q <= 1'b0;
                default:          oe_q <= 1'b0;
            endcase
        end
    end

    assign sda_oe_o = oe_q;

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
    import i2c_mem_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_i,
    input logic      start_det,
    input logic      stop_det,
    input logic      oe,
    input sl_state_t st,
    input logic [2:0] bit_cnt
);

    // R4: a new pull-down only begins while the clock line is low
    a_r4_drive_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> !scl_i);

    // R4: any change of drive happens with SCL low, or is a release forced by start/stop
    a_r4_change_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe) |-> (!scl_i || $past(start_det || stop_det)));

    // R8: a start clears the bit count and the drive, and begins a header
    a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (bit_cnt == 3'd0 && !oe && st == ST_DEV));

    // R8: a stop returns to idle with SDA released
    a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (st == ST_IDLE && !oe));

    // R7: the master's acknowledge slot is never driven by the slave
    a_r7_mack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MACK) |-> !oe);

    // R2: after a foreign address, the slave stays off the line
    a_r2_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> !oe);

endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .start_det (start_det),
    .stop_det  (stop_det),
    .oe        (sda_oe_o),
    .st        (st_q),
    .bit_cnt   (bit_q)
);

// File: tb/test_i2c_mem_slave.sv
`timescale 1ns/1ps
module test_i2c_mem_slave;

    localparam int AW = 11;
    localparam int Q  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic [2:0] strap = 3'b101;
    logic pl_we = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [7:0] pl_data = '0;
    logic sda_oe;
    logic sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int edge_viol = 0;
    logic oe_prev = 1'b0;
    logic done = 1'b0;
    logic [AW-1:0] m_addr = '0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    assign sda_bus = !(m_low || sda_oe);

    always #2.5 clk = ~clk;

    i2c_mem_slave #(.ADDR_W(AW)) i_i2c_mem_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe_o  (sda_oe),
        .strap_i   (strap),
        .pl_we_i   (pl_we),
        .pl_addr_i (pl_addr),
        .pl_data_i (pl_data)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ {a[10:8], 5'b0} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic exp_push(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (got_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] g;
            logic [7:0] e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(g == e, t, g, e);
        end
    end

    // R4 watcher: slave drive must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && m_scl) edge_viol++;
        oe_prev = sda_oe;
    end

    task automatic qw();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_low = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_low = 1'b1; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_low = 1'b0; qw();
    endtask

    task automatic send_bit(input logic b);
        m_low = !b; qw();
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; qw();
        m_scl = 1'b1; qw();
        b = sda_bus; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic nack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(nack);
    endtask

    task automatic rd_byte(output logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(!ack);
    endtask

    // read n bytes, ack all but the last, then check release (R7)
    task automatic rd_stream(input int n);
        logic [7:0] v;
        for (int k = 0; k < n; k++) begin
            rd_byte(v, k < n - 1);
            got_q.push_back(v);
        end
        chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    endtask

    task automatic cur_read(input int n, input string tag);
        logic nk;
        for (int k = 0; k < n; k++) exp_push(pat(m_addr + AW'(k)), tag);
        m_addr = m_addr + AW'(n);
        bus_start();
        wr_byte({4'b1010, strap, 1'b1}, nk);
        chk(nk == 1'b0, "R2 read header ack", nk, 0);
        rd_stream(n);
        bus_stop();
    endtask

    task automatic rand_read(input logic [15:0] word, input int n, input string tag);
        logic nk;
        logic [AW-1:0] a;
        a = word[AW-1:0];
        for (int k = 0; k < n; k++) exp_push(pat(a + AW'(k)), tag);
        m_addr = a + AW'(n);
        bus_start();
        wr_byte({4'b1010, strap, 1'b0}, nk);
        chk(nk == 1'b0, "R2 write header ack", nk, 0);
        wr_byte(word[15:8], nk);
        chk(nk == 1'b0, "R3 high address ack", nk, 0);
        wr_byte(word[7:0], nk);
        chk(nk == 1'b0, "R3 low address ack", nk, 0);
        bus_start();
        wr_byte({4'b1010, strap, 1'b1}, nk);
        chk(nk == 1'b0, "R3 repeated start read ack", nk, 0);
        rd_stream(n);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic nk;
        logic [7:0] v;
        repeat (4) @(posedge clk);
        #1;
        chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
        rst_n = 1'b1;
        qw();

        // R11: preload the whole array through the side port
        for (int a = 0; a < (1 << AW); a++) begin
            pl_we = 1'b1;
            pl_addr = AW'(a);
            pl_data = pat(AW'(a));
            @(posedge clk);
            #1;
        end
        pl_we = 1'b0;
        qw();

        // R1, R9, R11: first current read comes from address 0
        cur_read(1, "R1 first current read");
        // R3: upper word bits ignored
        rand_read(16'hF864, 1, "R3 random read");
        // R5: streaming from 0x200
        rand_read(16'h0200, 4, "R5 sequential");
        cur_read(1, "R9 continue after stream");
        // R6: roll over the top of the array
        rand_read(16'h07FE, 4, "R6 wrap");
        cur_read(1, "R9 continue after wrap");

        // R2: foreign address is ignored
        bus_start();
        wr_byte({4'b1010, 3'b011, 1'b1}, nk);
        chk(nk == 1'b1, "R2 foreign address not acked", nk, 1);
        rd_byte(v, 1'b1);
        chk(v == 8'hFF, "R2 foreign address no data", v, 8'hFF);
        bus_stop();

        // R2: new strap value selects the slave
        strap = 3'b010;
        cur_read(1, "R2 new strap read");

        // R7: clocks after a nack draw nothing from the slave
        exp_push(pat(m_addr), "R7 last byte");
        m_addr = m_addr + 1'b1;
        bus_start();
        wr_byte({4'b1010, strap, 1'b1}, nk);
        rd_stream(1);
        rd_byte(v, 1'b0);
        chk(v == 8'hFF, "R7 idle after nack", v, 8'hFF);
        bus_stop();

        // R10: single byte write, second byte refused
        bus_start();
        wr_byte({4'b1010, strap, 1'b0}, nk);
        wr_byte(8'h01, nk);
        wr_byte(8'h23, nk);
        wr_byte(8'hC3, nk);
        chk(nk == 1'b0, "R10 data byte acked", nk, 0);
        wr_byte(8'h99, nk);
        chk(nk == 1'b1, "R10 extra byte refused", nk, 1);
        bus_stop();
        m_addr = 11'h124;
        bus_start();
        wr_byte({4'b1010, strap, 1'b0}, nk);
        wr_byte(8'h01, nk);
        wr_byte(8'h23, nk);
        bus_start();
        wr_byte({4'b1010, strap, 1'b1}, nk);
        exp_push(8'hC3, "R10 stored byte");
        exp_push(pat(11'h124), "R10 neighbour untouched");
        rd_stream(2);
        bus_stop();
        m_addr = 11'h125;

        // R8: repeated start in the middle of the high address byte
        bus_start();
        wr_byte({4'b1010, strap, 1'b0}, nk);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        wr_byte({4'b1010, strap, 1'b1}, nk);
        chk(nk == 1'b0, "R8 header after mid-byte start", nk, 0);
        exp_push(pat(m_addr), "R8 counter kept after start abort");
        m_addr = m_addr + 1'b1;
        rd_stream(1);
        bus_stop();

        // R8: stop in the middle of a byte
        bus_start();
        wr_byte({4'b1010, strap, 1'b0}, nk);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_stop();
        cur_read(1, "R8 counter kept after stop abort");

        qw(); qw();
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        chk(edge_viol == 0, "R4 drive changes only with SCL low", edge_viol, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule